// File: doc/BRIEF.md
# Compensated Floating-Point Multiplier

This block multiplies two 64-bit floating-point words. Each word has a sign in bit 63, a biased 15-bit exponent in bits 62:48 (bias 0x4000), and a 48-bit fractional coefficient in bits 47:0. The coefficient's binary point sits above bit 47, so a normalized coefficient has bit 47 set. The block forms the full 96-bit coefficient product. It then adds a fixed compensation constant for the low product bits that a truncating array would drop. In the rounded and half-precision modes it also adds a pair of round bits. After that it normalizes by a single place, checks the exponent range, and packs the result word.

A mode input selects the precision for each operation: 2'b00 full precision without rounding, 2'b01 full precision rounded, 2'b10 half precision, and 2'b11 reserved. When both operand exponents are zero, the block does not follow the floating-point path. It returns the upper half of the raw coefficient product as an integer result with a zero exponent. The unit is a two-register pipeline: one register stage holds the product and one holds the result. It accepts a new operation every cycle, and the latency is the same in every mode.

Top module: `fmul_comp`

## Requirements
- R1: The result sign (bit 63) is the XOR of the two operand signs, whenever the result word is not all zeros.
- R2: The working exponent is the sum of the two exponent fields minus 0x4000. When bit 95 of the adjusted 96-bit product is set, result bits 47:0 are product bits 95:48 and the exponent is the working exponent.
- R3: When bits 96 and 95 of the adjusted product are both clear, the coefficient is bits 94:47 and the exponent is the working exponent minus one. With both inputs normalized, every in-range result has bit 47 set.
- R4: In every mode, 9 × 2^40 is added to the product before the normalization choice is made. The sum is allowed to carry into the kept bits.
- R5: In mode 2'b01, product bits 46 and 45 are also added before normalization.
- R6: In mode 2'b10, product bits 65 and 64 are added instead, and coefficient bits 18:0 of the result are forced to zero.
- R7: If the additions carry out past bit 95, the coefficient is bits 96:49 and the exponent is the working exponent plus one.
- R8: When both exponent fields are zero, the result is {sign, 15'h0, product bits 95:48}. No constant is added, no shift or mask is applied, and the error flag stays low. One zero exponent alone does not select this path.
- R9: A final exponent at or above 0x6000 gives an exponent field of exactly 0x6000 and raises the error flag. Sign and coefficient are kept. The value 0x5FFF passes unflagged.
- R10: A final exponent below 0x2000 gives an all-zero result word with the error flag low. The value 0x2000 passes unchanged.
- R11: Mode 2'b11 behaves exactly like mode 2'b00.
- R12: An operation accepted with in_valid at one rising edge appears with out_valid high after the second rising edge, for one cycle per operation. Reset clears out_valid, out_word and out_err. out_word and out_err hold their values while no result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request this cycle |
| in_mode | input | 2 | Precision select: 00 full, 01 full rounded, 10 half, 11 reserved |
| in_a | input | 64 | First operand word |
| in_b | input | 64 | Second operand word |
| out_valid | output | 1 | Result word valid |
| out_word | output | 64 | Result word |
| out_err | output | 1 | Exponent overflow flag |

## Verification
The bench uses the default parameters: a 15-bit exponent, a 48-bit coefficient and 29 kept half-precision bits. With these values the compensation carries sit at bit 40, the full round pair at bits 46:45 and the half round pair at bits 65:64. Coefficients such as 0x800000000001 against 0xF80000000000 or 0xC00000000000 therefore land carries exactly at these points. Each constant is shown both alone and in combination. The same parameters put the 0x2000 and 0x6000 exponent limits within reach of operands at 0x3000 and 0x5000. All-ones coefficients drive the product to a carry past bit 95.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    // Precision select carried through the pipeline
    typedef enum logic [1:0] {
        MODE_FULL = 2'b00,
        MODE_RND  = 2'b01,
        MODE_HALF = 2'b10,
        MODE_RSVD = 2'b11
    } fmul_mode_e;

endpackage

// File: rtl/fmul_mul_stage.sv
// First pipeline stage: field split, sign, exponent sum and raw product.
module fmul_mul_stage
    import fmul_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int COEF_W = 48,
    localparam int WORD_W = 1 + EXP_W + COEF_W,
    localparam int PROD_W = 2 * COEF_W,
    localparam int SE_W   = EXP_W + 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  fmul_mode_e               in_mode,
    input  logic [WORD_W-1:0]        in_a,
    input  logic [WORD_W-1:0]        in_b,
    output logic                     s1_valid,
    output logic                     s1_sign,
    output logic signed [SE_W-1:0]   s1_exp,
    output logic [PROD_W-1:0]        s1_prod,
    output logic                     s1_int,
    output fmul_mode_e               s1_mode
);

    localparam int BIAS = 1 << (EXP_W - 1);

    logic [EXP_W-1:0]      exp_a, exp_b;
    logic [COEF_W-1:0]     coef_a, coef_b;
    logic signed [SE_W-1:0] exp_sum;
    logic [PROD_W-1:0]     prod;

    always_comb begin
        exp_a   = in_a[WORD_W-2 -: EXP_W];
        exp_b   = in_b[WORD_W-2 -: EXP_W];
        coef_a  = in_a[COEF_W-1:0];
        coef_b  = in_b[COEF_W-1:0];
        exp_sum = $signed({3'b000, exp_a}) + $signed({3'b000, exp_b})
                  - $signed(SE_W'(BIAS));
        prod    = PROD_W'(coef_a) * PROD_W'(coef_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_exp   <= '0;
            s1_prod  <= '0;
            s1_int   <= 1'b0;
            s1_mode  <= MODE_FULL;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_sign <= in_a[WORD_W-1] ^ in_b[WORD_W-1];
                s1_exp  <= exp_sum;
                s1_prod <= prod;
                s1_int  <= (exp_a == '0) && (exp_b == '0);
                s1_mode <= in_mode;
            end
        end
    end

endmodule

// File: rtl/fmul_round_norm.sv
// Adds compensation and round constants, then normalizes by one place.
module fmul_round_norm
    import fmul_pkg::*;
#(
    parameter int COEF_W    = 48,
    parameter int HALF_KEEP = 29,
    parameter int COMP_POS  = 40,
    parameter int COMP_VAL  = 9,
    localparam int PROD_W = 2 * COEF_W,
    localparam int SUM_W  = PROD_W + 1,
    localparam int FULL_R = PROD_W - COEF_W - 2,
    localparam int HALF_R = PROD_W - HALF_KEEP - 2,
    localparam int DROP_W = COEF_W - HALF_KEEP
) (
    input  logic [PROD_W-1:0]   prod,
    input  fmul_mode_e          mode,
    output logic [COEF_W-1:0]   coef,
    output logic signed [1:0]   exp_adj
);

    localparam logic [SUM_W-1:0] COMP_ADD  = SUM_W'(COMP_VAL) << COMP_POS;
    localparam logic [SUM_W-1:0] FULL_ADD  = (SUM_W'(1) << FULL_R) | (SUM_W'(1) << (FULL_R - 1));
    localparam logic [SUM_W-1:0] HALF_ADD  = (SUM_W'(1) << HALF_R) | (SUM_W'(1) << (HALF_R - 1));
    localparam logic [COEF_W-1:0] HALF_MSK = {{HALF_KEEP{1'b1}}, {DROP_W{1'b0}}};

    logic [SUM_W-1:0]  addend;
    logic [SUM_W-1:0]  sum;
    logic [COEF_W-1:0] picked;

    always_comb begin
        addend = COMP_ADD;
        unique case (mode)
            MODE_RND:  addend = COMP_ADD + FULL_ADD;
            MODE_HALF: addend = COMP_ADD + HALF_ADD;
            MODE_FULL,
            MODE_RSVD: addend = COMP_ADD;
        endcase
        sum = {1'b0, prod} + addend;

        if (sum[SUM_W-1]) begin
            picked  = sum[SUM_W-1 -: COEF_W];
            exp_adj = 2'sd1;
        end else if (sum[PROD_W-1]) begin
            picked  = sum[PROD_W-1 -: COEF_W];
            exp_adj = 2'sd0;
        end else begin
            picked  = sum[PROD_W-2 -: COEF_W];
            exp_adj = -2'sd1;
        end

        coef = (mode == MODE_HALF) ? (picked & HALF_MSK) : picked;
    end

endmodule

// File: rtl/fmul_range.sv
// Exponent window check, integer bypass and result packing.
module fmul_range #(
    parameter int EXP_W  = 15,
    parameter int COEF_W = 48,
    localparam int WORD_W = 1 + EXP_W + COEF_W,
    localparam int SE_W   = EXP_W + 3
) (
    input  logic                    sign,
    input  logic signed [SE_W-1:0]  exp_in,
    input  logic signed [1:0]       exp_adj,
    input  logic [COEF_W-1:0]       coef,
    input  logic                    is_int,
    input  logic [COEF_W-1:0]       int_coef,
    output logic [WORD_W-1:0]       word,
    output logic                    err
);

    localparam logic signed [SE_W-1:0] OVF_E = SE_W'(3 << (EXP_W - 2));
    localparam logic signed [SE_W-1:0] UDF_E = SE_W'(1 << (EXP_W - 2));

    logic signed [SE_W-1:0] exp_fin;
    logic                   ovf, udf;

    always_comb begin
        exp_fin = exp_in + SE_W'(exp_adj);
        ovf     = exp_fin >= OVF_E;
        udf     = exp_fin < UDF_E;
        err     = 1'b0;
        if (is_int) begin
            word = {sign, {EXP_W{1'b0}}, int_coef};
        end else if (ovf) begin
            word = {sign, OVF_E[EXP_W-1:0], coef};
            err  = 1'b1;
        end else if (udf) begin
            word = '0;
        end else begin
            word = {sign, exp_fin[EXP_W-1:0], coef};
        end
    end

endmodule

// File: rtl/fmul_comp.sv
// Top: two register stages around the product, rounding and range logic.
module fmul_comp
    import fmul_pkg::*;
#(
    parameter int EXP_W     = 15,
    parameter int COEF_W    = 48,
    parameter int HALF_KEEP = 29,
    parameter int COMP_POS  = 40,
    parameter int COMP_VAL  = 9,
    localparam int WORD_W = 1 + EXP_W + COEF_W,
    localparam int PROD_W = 2 * COEF_W,
    localparam int SE_W   = EXP_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_err
);

    logic                   s1_valid, s1_sign, s1_int;
    logic signed [SE_W-1:0] s1_exp;
    logic [PROD_W-1:0]      s1_prod;
    fmul_mode_e             s1_mode;
    logic [COEF_W-1:0]      nrm_coef;
    logic signed [1:0]      nrm_adj;
    logic [WORD_W-1:0]      res_word;
    logic                   res_err;

    fmul_mul_stage #(.EXP_W(EXP_W), .COEF_W(COEF_W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_mode  (fmul_mode_e'(in_mode)),
        .in_a     (in_a),
        .in_b     (in_b),
        .s1_valid (s1_valid),
        .s1_sign  (s1_sign),
        .s1_exp   (s1_exp),
        .s1_prod  (s1_prod),
        .s1_int   (s1_int),
        .s1_mode  (s1_mode)
    );

    fmul_round_norm #(
        .COEF_W(COEF_W), .HALF_KEEP(HALF_KEEP),
        .COMP_POS(COMP_POS), .COMP_VAL(COMP_VAL)
    ) u_norm (
        .prod    (s1_prod),
        .mode    (s1_mode),
        .coef    (nrm_coef),
        .exp_adj (nrm_adj)
    );

    fmul_range #(.EXP_W(EXP_W), .COEF_W(COEF_W)) u_range (
        .sign     (s1_sign),
        .exp_in   (s1_exp),
        .exp_adj  (nrm_adj),
        .coef     (nrm_coef),
        .is_int   (s1_int),
        .int_coef (s1_prod[PROD_W-1 -: COEF_W]),
        .word     (res_word),
        .err      (res_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_word <= res_word;
                out_err  <= res_err;
            end
        end
    end

endmodule

// File: rtl/fmul_comp_chk.sv
module fmul_comp_chk #(
    parameter int EXP_W     = 15,
    parameter int COEF_W    = 48,
    parameter int HALF_KEEP = 29,
    localparam int WORD_W = 1 + EXP_W + COEF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_mode,
    input logic [WORD_W-1:0] in_a,
    input logic [WORD_W-1:0] in_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input logic              out_err
);

    localparam logic [EXP_W-1:0] OVF_E = EXP_W'(3 << (EXP_W - 2));
    localparam logic [EXP_W-1:0] UDF_E = EXP_W'(1 << (EXP_W - 2));

    logic [EXP_W-1:0] out_exp;
    logic             a_norm, b_norm;
    assign out_exp = out_word[WORD_W-2 -: EXP_W];
    assign a_norm  = in_a[COEF_W-1] && (in_a[WORD_W-2 -: EXP_W] != '0);
    assign b_norm  = in_b[COEF_W-1] && (in_b[WORD_W-2 -: EXP_W] != '0);

    p_valid_lat_r12: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    p_idle_lat_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    p_sign_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word != '0) |->
            out_word[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1], 2));

    p_norm_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exp != '0 && $past(a_norm && b_norm, 2)) |->
            out_word[COEF_W-1]);

    p_half_low_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exp != '0 && $past(in_mode, 2) == 2'b10) |->
            out_word[COEF_W-HALF_KEEP-1:0] == '0);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> out_exp == OVF_E);

    p_exp_window_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exp != '0) |-> (out_exp >= UDF_E && out_exp <= OVF_E));

endmodule

bind fmul_comp fmul_comp_chk #(
    .EXP_W(EXP_W), .COEF_W(COEF_W), .HALF_KEEP(HALF_KEEP)
) u_chk (.*);

// File: tb/fmul_comp_tb.sv
module fmul_comp_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_word;
    logic        out_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmul_comp u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_word(out_word), .out_err(out_err)
    );

    // {mode, a, b, expected word, expected flag}
    localparam logic [194:0] VEC [NVEC] = '{
        {2'b00, 64'h4000_8000_0000_0000, 64'h4000_8000_0000_0000, 64'h3FFF_8000_0000_0000, 1'b0}, // R3
        {2'b00, 64'h4000_FFFF_FFFF_FFFF, 64'h4000_FFFF_FFFF_FFFF, 64'h4000_FFFF_FFFF_FFFE, 1'b0}, // R2
        {2'b10, 64'h4000_FFFF_FFFF_FFFF, 64'h4000_FFFF_FFFF_FFFF, 64'h4001_8000_0000_0000, 1'b0}, // R7 R6
        {2'b00, 64'h4000_8000_0000_0001, 64'h4000_C000_0000_0000, 64'h3FFF_C000_0000_0001, 1'b0}, // R4
        {2'b01, 64'h4000_8000_0000_0001, 64'h4000_C000_0000_0000, 64'h3FFF_C000_0000_0002, 1'b0}, // R5
        {2'b10, 64'h4000_8000_0000_0001, 64'h4000_C000_0000_0000, 64'h3FFF_C000_0000_0000, 1'b0}, // R6
        {2'b11, 64'h4000_8000_0000_0001, 64'h4000_C000_0000_0000, 64'h3FFF_C000_0000_0001, 1'b0}, // R11
        {2'b00, 64'h4000_8000_0000_0001, 64'h4000_F800_0000_0000, 64'h3FFF_F800_0000_0002, 1'b0}, // R4
        {2'b10, 64'h4000_8000_0000_0001, 64'h4000_F800_0000_0000, 64'h3FFF_F800_0000_0000, 1'b0}, // R6
        {2'b10, 64'h8000_8000_0000_0000, 64'h0000_0000_0000_0006, 64'h8000_0000_0000_0003, 1'b0}, // R8
        {2'b00, 64'hC000_8000_0000_0000, 64'h4000_8000_0000_0000, 64'hBFFF_8000_0000_0000, 1'b0}, // R1
        {2'b00, 64'hC000_8000_0000_0000, 64'hC000_8000_0000_0000, 64'h3FFF_8000_0000_0000, 1'b0}, // R1
        {2'b00, 64'h5000_FFFF_FFFF_FFFF, 64'h5000_FFFF_FFFF_FFFF, 64'h6000_FFFF_FFFF_FFFE, 1'b1}, // R9
        {2'b00, 64'h5000_8000_0000_0000, 64'h5000_8000_0000_0000, 64'h5FFF_8000_0000_0000, 1'b0}, // R9 edge
        {2'b00, 64'hB000_8000_0000_0000, 64'h3000_8000_0000_0000, 64'h0000_0000_0000_0000, 1'b0}, // R10
        {2'b00, 64'hB000_FFFF_FFFF_FFFF, 64'h3000_FFFF_FFFF_FFFF, 64'hA000_FFFF_FFFF_FFFE, 1'b0}, // R10 edge
        {2'b10, 64'hD000_FFFF_FFFF_FFFF, 64'h5000_FFFF_FFFF_FFFF, 64'hE000_8000_0000_0000, 1'b1}, // R9 R7
        {2'b00, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFE, 1'b0}, // R8
        {2'b00, 64'h0000_8000_0000_0000, 64'h4000_8000_0000_0000, 64'h0000_0000_0000_0000, 1'b0}  // R8 one zero
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Drive one operation, wait two rising edges, sample at the falling edge.
    task automatic issue(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_mode  = m;
        in_a     = a;
        in_b     = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(out_valid == 1'b0, "R12 reset valid", 64'(out_valid), 64'd0);
        chk(out_word == '0 && out_err == 1'b0, "R12 reset word", out_word, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][194:193], VEC[i][192:129], VEC[i][128:65]);
            chk(out_valid == 1'b1, $sformatf("R12 vec%0d valid", i), 64'(out_valid), 64'd1);
            chk(out_word == VEC[i][64:1], $sformatf("vec%0d word (R1..R11)", i), out_word, VEC[i][64:1]);
            chk(out_err == VEC[i][0], $sformatf("R9 vec%0d flag", i), 64'(out_err), 64'(VEC[i][0]));
        end

        // R12: single-cycle valid pulse, result held while idle
        @(negedge clk);
        in_a = 64'h4000_FFFF_FFFF_FFFF;
        in_b = 64'h4000_FFFF_FFFF_FFFF;
        chk(out_valid == 1'b0, "R12 pulse ends", 64'(out_valid), 64'd0);
        repeat (3) @(negedge clk);
        chk(out_word == VEC[NVEC-1][64:1], "R12 hold idle", out_word, VEC[NVEC-1][64:1]);

        // R12: back-to-back operations stream one per cycle
        @(negedge clk);
        in_mode = 2'b00; in_a = VEC[0][192:129]; in_b = VEC[0][128:65]; in_valid = 1'b1;
        @(negedge clk);
        in_mode = 2'b01; in_a = VEC[4][192:129]; in_b = VEC[4][128:65];
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_word == VEC[0][64:1], "R12 stream first", out_word, VEC[0][64:1]);
        @(negedge clk);
        chk(out_valid && out_word == VEC[4][64:1], "R5 R12 stream second", out_word, VEC[4][64:1]);

        // R12: reset clears a pending result
        @(negedge clk);
        in_a = VEC[12][192:129]; in_b = VEC[12][128:65]; in_mode = 2'b00; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_err == 1'b0 && out_word == '0, "R12 reset flush", out_word, 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R12 no result after flush", 64'(out_valid), 64'd0);

        finish_run();
    end

endmodule